// File: doc/BRIEF.md
# Page ECC Generator and Checker

This unit computes a 24-bit error-correcting code for each 256-byte half of a 512-byte page as the bytes stream past. A sequencer tracks the byte position within the page. It steers each accepted byte into the accumulator for its half, and it also supplies the byte's offset within that half. When a page is written, the two finished code words are read straight from the outputs and stored next to the data.

When a page is read back, the same accumulation runs over the data that arrives. The previously stored codes are then presented with a check strobe. The unit forms the syndrome for each half and classifies it as clean, a single-bit error it can locate, or an uncorrectable error. It returns the outcome as one packed 32-bit result word. Applying the fix is left to the consumer: XOR the byte at the reported offset with `1 << bit`.

The sequencer has four states:
- ST_FIRST: accepting bytes 0 to 255.
- ST_SECOND: accepting bytes 256 to 511.
- ST_FULL: the page is closed and no more bytes are accepted.
- ST_EVAL: the one-cycle evaluation after a check strobe.

Its transitions are:
- FIRST→SECOND: the 256th byte is accepted.
- SECOND→FULL: the 512th byte is accepted.
- FIRST/SECOND/FULL→EVAL: a check strobe arrives.
- EVAL→FULL: this transition is unconditional.
- any→FIRST: a clear is applied.

Top module: `ecc_page_unit`

## Requirements
- R1: Each code word `codeN` reads as `{8'h00, 2'b11, ~P}`, where P is 22 parity bits. P[2k+1] is the XOR of all bits of the bytes whose offset bit k is 1, and P[2k] covers the bytes whose offset bit k is 0, for k=0..7. P[16+2j+1] is the XOR over the data bit positions whose index bit j is 1, and P[16+2j] covers the positions whose index bit j is 0, taken over all bytes of the half, for j=0..2.
- R2: The first 256 accepted bytes of a page feed `code0` only, with offsets 0..255 in arrival order. The next 256 accepted bytes feed `code1` only.
- R3: A byte is accepted only when `din_valid` and `acc_en` are both 1. Any other byte leaves both codes unchanged.
- R4: After 512 bytes have been accepted, further bytes leave both codes unchanged until `clear` is applied.
- R5: `clear` (synchronous) restarts the page. The cycle after it, both code words read 32'h00FFFFFF and `result_valid` is 0. `clear` overrides a simultaneous `check_go`.
- R6: `check_go` captures `stored0`/`stored1`, which are the 22 inverted parity bits of each stored code. `result_valid` is 0 in the cycle after the strobe and is 1 with a new `result` in the cycle after that. It remains 1 until the next clear or strobe.
- R7: `result[15:0]` reports half 0 and `result[31:16]` reports half 1. In each field, the low byte is the erroneous byte's offset and the high byte is status: bit 7 = fail, bit 6 = correctable, bits 2:0 = bit index, other bits 0.
- R8: A zero syndrome (computed XOR stored) gives an all-zero field.
- R9: If each of the 11 parity pairs in the syndrome differs in exactly one bit, the error is a correctable single-bit error. The offset is taken from syndrome bits 2k+1 and the bit index from bits 16+2j+1.
- R10: Any other nonzero syndrome sets only the fail flag, with offset 0 and bit index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Enables code accumulation |
| clear | input | 1 | Restarts the page (synchronous) |
| din_valid | input | 1 | Byte strobe |
| din | input | 8 | Data byte |
| check_go | input | 1 | Starts a comparison with the stored codes |
| stored0 | input | 22 | Stored inverted parity for half 0 |
| stored1 | input | 22 | Stored inverted parity for half 1 |
| code0 | output | 32 | Running code word for half 0 |
| code1 | output | 32 | Running code word for half 1 |
| result | output | 32 | Packed per-half result |
| result_valid | output | 1 | `result` holds a finished evaluation |

## Verification
A byte accepted at one rising edge shows in the code words from that edge onward, so the bench reads the codes on the falling edge after the last byte it drives. The check result takes two edges: one to capture the stored codes and enter evaluation, and one to register the result. The bench therefore samples `result_valid` low one falling edge after the strobe, then samples it high together with `result` at the following falling edge. Every input changes on a falling edge, so no sample can coincide with an input change.

// File: rtl/ecc_pg_pkg.sv
package ecc_pg_pkg;

    typedef enum logic [1:0] {
        ST_FIRST  = 2'd0,
        ST_SECOND = 2'd1,
        ST_FULL   = 2'd2,
        ST_EVAL   = 2'd3
    } ecc_state_t;

    localparam int STATUS_W = 8;
    localparam int FAIL_POS = 7;
    localparam int CORR_POS = 6;

endpackage

// File: rtl/ecc_pg_accum.sv
module ecc_pg_accum #(
    parameter int OFS_W = 8,
    parameter int BIT_W = 3,
    localparam int DW   = 1 << BIT_W,
    localparam int LPW  = 2 * OFS_W,
    localparam int PW   = LPW + 2 * BIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [OFS_W-1:0] ofs,
    input  logic [DW-1:0]    data,
    output logic [PW-1:0]    par
);

    logic          bpar;
    logic [PW-1:0] flip;

    assign bpar = ^data;

    // line parity: one pair per offset bit
    for (genvar k = 0; k < OFS_W; k++) begin : g_line
        assign flip[2*k+1] = bpar & ofs[k];
        assign flip[2*k]   = bpar & ~ofs[k];
    end

    // column parity: one pair per bit-index bit
    for (genvar j = 0; j < BIT_W; j++) begin : g_col
        logic [1:0] cpar;
        always_comb begin
            cpar = '0;
            for (int b = 0; b < DW; b++) begin
                if (((b >> j) & 1) != 0) cpar[1] = cpar[1] ^ data[b];
                else                     cpar[0] = cpar[0] ^ data[b];
            end
        end
        assign flip[LPW+2*j+1] = cpar[1];
        assign flip[LPW+2*j]   = cpar[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    par <= '0;
        else if (clr)  par <= '0;
        else if (take) par <= par ^ flip;
    end

    // R3: nothing changes the parity without an accepted byte
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clr) |=> $stable(par));

    // R5: clear empties the accumulator
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (par == '0));

endmodule

// File: rtl/ecc_pg_decode.sv
module ecc_pg_decode #(
    parameter int OFS_W = 8,
    parameter int BIT_W = 3,
    localparam int LPW  = 2 * OFS_W,
    localparam int NP   = OFS_W + BIT_W,
    localparam int PW   = 2 * NP
) (
    input  logic [PW-1:0]    calc,
    input  logic [PW-1:0]    stored,
    output logic             fail,
    output logic             corr,
    output logic [OFS_W-1:0] err_ofs,
    output logic [BIT_W-1:0] err_bit
);

    logic [PW-1:0] syn;
    logic [NP-1:0] pair_one;
    logic          any;

    assign syn = calc ^ stored;
    assign any = |syn;

    for (genvar i = 0; i < NP; i++) begin : g_pair
        assign pair_one[i] = syn[2*i] ^ syn[2*i+1];
    end

    assign corr = any & (&pair_one);
    assign fail = any & ~(&pair_one);

    for (genvar k = 0; k < OFS_W; k++) begin : g_ofs
        assign err_ofs[k] = corr & syn[2*k+1];
    end

    for (genvar j = 0; j < BIT_W; j++) begin : g_bit
        assign err_bit[j] = corr & syn[LPW+2*j+1];
    end

endmodule

// File: rtl/ecc_pg_ctrl.sv
module ecc_pg_ctrl
    import ecc_pg_pkg::*;
#(
    parameter int OFS_W = 8,
    localparam int CW   = OFS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             acc_en,
    input  logic             din_vld,
    input  logic             go,
    output logic             take,
    output logic             half_sel,
    output logic [OFS_W-1:0] ofs,
    output logic             cap,
    output logic             load,
    output logic             in_first,
    output logic             res_valid
);

    localparam logic [OFS_W-1:0] LAST = '1;

    ecc_state_t    st, st_nx;
    logic [CW-1:0] cnt;
    logic          open_st;

    assign ofs      = cnt[OFS_W-1:0];
    assign half_sel = cnt[OFS_W];

    // outputs
    always_comb begin
        open_st  = (st == ST_FIRST) || (st == ST_SECOND);
        take     = open_st && acc_en && din_vld && !clr;
        cap      = (st != ST_EVAL) && go && !clr;
        load     = (st == ST_EVAL) && !clr;
        in_first = (st == ST_FIRST);
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_FIRST:  if (cap) st_nx = ST_EVAL;
                       else if (take && ofs == LAST) st_nx = ST_SECOND;
            ST_SECOND: if (cap) st_nx = ST_EVAL;
                       else if (take && ofs == LAST) st_nx = ST_FULL;
            ST_FULL:   if (cap) st_nx = ST_EVAL;
            ST_EVAL:   st_nx = ST_FULL;
            default:   st_nx = ST_FIRST;
        endcase
        if (clr) st_nx = ST_FIRST;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_FIRST;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (take) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    res_valid <= 1'b0;
        else if (clr)  res_valid <= 1'b0;
        else if (cap)  res_valid <= 1'b0;
        else if (load) res_valid <= 1'b1;
    end

    // R2: the first state only ever addresses half 0
    a_r2_first_is_half0: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIRST) |-> !half_sel);

    // R4: a closed page keeps its byte count
    a_r4_full_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FULL && !clr) |=> $stable(cnt));

    // R5: clear restarts the sequencer
    a_r5_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && st == ST_FIRST && !res_valid));

    // R6: a result becomes valid only after the evaluation state
    a_r6_valid_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(st == ST_EVAL));

    // R6: the strobe drops validity for the next cycle
    a_r6_go_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !res_valid);

endmodule

// File: rtl/ecc_page_unit.sv
module ecc_page_unit
    import ecc_pg_pkg::*;
#(
    parameter int OFS_W  = 8,
    parameter int BIT_W  = 3,
    parameter int WORD_W = 32,
    localparam int DW    = 1 << BIT_W,
    localparam int PW    = 2 * (OFS_W + BIT_W),
    localparam int CODE_W = PW + 2,
    localparam int FLD_W = STATUS_W + OFS_W,
    localparam int PAD_STAT = STATUS_W - 2 - BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              clear,
    input  logic              din_valid,
    input  logic [DW-1:0]     din,
    input  logic              check_go,
    input  logic [PW-1:0]     stored0,
    input  logic [PW-1:0]     stored1,
    output logic [WORD_W-1:0] code0,
    output logic [WORD_W-1:0] code1,
    output logic [WORD_W-1:0] result,
    output logic              result_valid
);

    logic             take, half_sel, cap, load, in_first;
    logic [OFS_W-1:0] ofs;
    logic [PW-1:0]    par     [2];
    logic [PW-1:0]    inv     [2];
    logic [PW-1:0]    ref_q   [2];
    logic [PW-1:0]    ref_in  [2];
    logic [1:0]       h_fail, h_corr;
    logic [OFS_W-1:0] h_ofs   [2];
    logic [BIT_W-1:0] h_bit   [2];
    logic [2*FLD_W-1:0] res_nx;

    assign ref_in[0] = stored0;
    assign ref_in[1] = stored1;

    ecc_pg_ctrl #(.OFS_W(OFS_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clear),
        .acc_en    (acc_en),
        .din_vld   (din_valid),
        .go        (check_go),
        .take      (take),
        .half_sel  (half_sel),
        .ofs       (ofs),
        .cap       (cap),
        .load      (load),
        .in_first  (in_first),
        .res_valid (result_valid)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        ecc_pg_accum #(.OFS_W(OFS_W), .BIT_W(BIT_W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clear),
            .take  (take && (half_sel == h[0])),
            .ofs   (ofs),
            .data  (din),
            .par   (par[h])
        );

        assign inv[h] = ~par[h];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ref_q[h] <= '0;
            else if (cap) ref_q[h] <= ref_in[h];
        end

        ecc_pg_decode #(.OFS_W(OFS_W), .BIT_W(BIT_W)) u_dec (
            .calc    (inv[h]),
            .stored  (ref_q[h]),
            .fail    (h_fail[h]),
            .corr    (h_corr[h]),
            .err_ofs (h_ofs[h]),
            .err_bit (h_bit[h])
        );

        assign res_nx[h*FLD_W +: FLD_W] =
            {h_fail[h], h_corr[h], {PAD_STAT{1'b0}}, h_bit[h], h_ofs[h]};

        // R8: matching codes give a clean field
        a_r8_clean_field: assert property (@(posedge clk) disable iff (!rst_n)
            (load && ref_q[h] == inv[h]) |=> (result[h*FLD_W +: FLD_W] == '0));

        // R10: a field never claims both fail and correctable
        a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            result_valid |-> !(result[h*FLD_W + OFS_W + FAIL_POS]
                             && result[h*FLD_W + OFS_W + CORR_POS]));
    end

    assign code0 = {{(WORD_W-CODE_W){1'b0}}, 2'b11, inv[0]};
    assign code1 = {{(WORD_W-CODE_W){1'b0}}, 2'b11, inv[1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     result <= '0;
        else if (clear) result <= '0;
        else if (load)  result <= {{(WORD_W-2*FLD_W){1'b0}}, res_nx};
    end

    // R2: half 1 is untouched while the first half streams
    a_r2_half1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_first && !clear) |=> $stable(par[1]));

    // R6: the result only moves on an evaluation or a clear
    a_r6_result_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clear) |=> $stable(result));

endmodule

// File: tb/ecc_page_unit_tb.sv
module ecc_page_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, clear = 1'b0, din_valid = 1'b0, check_go = 1'b0;
    logic [7:0]  din = '0;
    logic [21:0] stored0 = '0, stored1 = '0;
    logic [31:0] code0, code1, result;
    logic        result_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [7:0] pg [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_page_unit u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .clear(clear),
        .din_valid(din_valid), .din(din), .check_go(check_go),
        .stored0(stored0), .stored1(stored1),
        .code0(code0), .code1(code1), .result(result),
        .result_valid(result_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference code word per R1, from the current page image
    function automatic logic [31:0] ref_code(input int base);
        logic [15:0] lp;
        logic [5:0]  cp;
        lp = '0;
        cp = '0;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] d;
            logic [7:0] o;
            logic       p;
            d = pg[base+i];
            o = 8'(i);
            p = ^d;
            for (int k = 0; k < 8; k++) lp[2*k + int'(o[k])] ^= p;
            for (int j = 0; j < 3; j++)
                for (int b = 0; b < 8; b++) cp[2*j + ((b >> j) & 1)] ^= d[b];
        end
        return {8'h00, 2'b11, ~cp, ~lp};
    endfunction

    task automatic fill_random();
        for (int i = 0; i < 512; i++) pg[i] = 8'($urandom);
    endtask

    // junk: insert bytes with acc_en low; gaps: insert cycles with valid low
    task automatic send_page(input bit junk, input bit gaps);
        for (int i = 0; i < 512; i++) begin
            if (junk && ($urandom % 3 == 0)) begin
                @(negedge clk);
                acc_en = 1'b0; din_valid = 1'b1; din = 8'($urandom);
            end
            if (gaps && ($urandom % 4 == 0)) begin
                @(negedge clk);
                acc_en = 1'b1; din_valid = 1'b0; din = 8'($urandom);
            end
            @(negedge clk);
            acc_en = 1'b1; din_valid = 1'b1; din = pg[i];
        end
        @(negedge clk);
        din_valid = 1'b0; acc_en = 1'b1;
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic run_check(input logic [31:0] s0, input logic [31:0] s1,
                             input logic [31:0] exp, input string req);
        @(negedge clk);
        check_go = 1'b1; stored0 = s0[21:0]; stored1 = s1[21:0];
        @(negedge clk);
        check_go = 1'b0;
        check("R6 valid low after strobe", {31'd0, result_valid}, 32'd0);
        @(negedge clk);
        check("R6 valid high", {31'd0, result_valid}, 32'd1);
        check(req, result, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] c0, c1;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 reset code0", code0, 32'h00FFFFFF);
        check("R5 reset code1", code1, 32'h00FFFFFF);
        check("R5 reset valid", {31'd0, result_valid}, 32'd0);

        // R1 R2 R3 R8: random pages with gaps and disabled bytes
        for (int n = 0; n < 4; n++) begin
            do_clear();
            fill_random();
            send_page(n[0], 1'b1);
            c0 = ref_code(0); c1 = ref_code(256);
            check("R1 R2 code0", code0, c0);
            check("R1 R2 code1", code1, c1);
            run_check(c0, c1, 32'h0, "R8 clean page");
        end

        // R2: a lone byte lands in half 0
        do_clear();
        for (int i = 0; i < 512; i++) pg[i] = 8'h00;
        pg[0] = 8'h01;
        @(negedge clk); acc_en = 1; din_valid = 1; din = 8'h01;
        @(negedge clk); din_valid = 0;
        check("R2 lone byte half0", code0, ref_code(0));
        check("R2 lone byte half1 idle", code1, 32'h00FFFFFF);

        // R9: random single-bit errors in either half
        for (int n = 0; n < 6; n++) begin
            int h, b, t;
            logic [31:0] exp;
            do_clear();
            fill_random();
            c0 = ref_code(0); c1 = ref_code(256);
            h = $urandom % 2; b = $urandom % 256; t = $urandom % 8;
            pg[h*256 + b] ^= 8'(1 << t);
            send_page(1'b0, 1'b0);
            exp = {16'h4000 | 16'(t << 8) | 16'(b)} << (16*h);
            run_check(c0, c1, exp, "R9 R7 single-bit");
        end

        // R7 R9: directed corners, byte 255 bit 7 of half 1 and byte 0 bit 0 of half 0
        do_clear();
        fill_random();
        c0 = ref_code(0); c1 = ref_code(256);
        pg[511] ^= 8'h80;
        pg[0]   ^= 8'h01;
        send_page(1'b0, 1'b0);
        run_check(c0, c1, 32'h47FF_4000, "R7 R9 corner packing");

        // R10: two flips in half 1
        do_clear();
        fill_random();
        c0 = ref_code(0); c1 = ref_code(256);
        pg[300] ^= 8'h04;
        pg[301] ^= 8'h10;
        send_page(1'b0, 1'b0);
        run_check(c0, c1, 32'h8000_0000, "R10 double error half1");

        // R10: two flips in the same byte of half 0
        do_clear();
        fill_random();
        c0 = ref_code(0); c1 = ref_code(256);
        pg[17] ^= 8'h81;
        send_page(1'b0, 1'b0);
        run_check(c0, c1, 32'h0000_8000, "R10 double error same byte");

        // R3 R4: junk with enable low, then bytes past the page end
        do_clear();
        fill_random();
        send_page(1'b1, 1'b0);
        c0 = ref_code(0); c1 = ref_code(256);
        check("R3 disabled bytes ignored", code0, c0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); acc_en = 1; din_valid = 1; din = 8'($urandom);
        end
        @(negedge clk); din_valid = 0;
        check("R4 extra bytes code0", code0, c0);
        check("R4 extra bytes code1", code1, c1);

        // R5: clear wins over check
        @(negedge clk); clear = 1; check_go = 1;
        @(negedge clk); clear = 0; check_go = 0;
        @(negedge clk);
        check("R5 clear over check valid", {31'd0, result_valid}, 32'd0);
        check("R5 clear code0", code0, 32'h00FFFFFF);
        check("R5 clear result", result, 32'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule